// File: doc/BRIEF.md
# Dual-Lane Halfword Saturation Unit

This block treats a 32-bit operand as two packed signed 16-bit lanes and clamps each lane, on its own, to a range set at run time by a saturation position. A mode input selects between two kinds of range. Signed mode gives a symmetric two's-complement range. Unsigned mode gives a range from zero up to an all-ones value. Each lane's result goes back into the halfword it came from, so the output is a packed 32-bit word.

The datapath has one register stage. An operation is presented with `in_valid`. One clock later the block returns the packed result, a bit that says whether any lane was clamped, and `out_valid`. A sticky flag collects every clamp event and is cleared only by the synchronous `sticky_clr` input or by reset. A saturation position outside the legal range for the chosen mode raises an error. In that case the previous result and the sticky flag are left as they were.

Top module: `hsat_dual_unit`

## Requirements
- R1: The low lane is `in_opnd[15:0]` and the high lane is `in_opnd[31:16]`. Each lane is clamped independently, and its result is placed in the same bit positions of `out_data`.
- R2: With `in_mode`=0 (signed) and `in_sat`=s, where 1 ≤ s ≤ 16, each lane x becomes min(max(x, -2^(s-1)), 2^(s-1)-1). The result is written as a 16-bit two's-complement value.
- R3: With `in_mode`=1 (unsigned) and `in_sat`=s, where 0 ≤ s ≤ 15, each lane x becomes min(max(x, 0), 2^s-1), so every negative lane becomes 0.
- R4: In signed mode with s=16, the operand passes through unchanged and `out_sat` stays 0. In unsigned mode with s=0, the result is 0, and `out_sat` is 1 exactly when some input lane is nonzero.
- R5: `out_sat` is 1 exactly when at least one lane's result differs from its input.
- R6: `sticky_q` resets to 0 and becomes 1 one cycle after any accepted operation that clamps a lane. An operation that clamps nothing never clears it.
- R7: A high `sticky_clr` clears `sticky_q` at the next clock edge. If a clamping operation is accepted in the same cycle, the flag ends up 1.
- R8: A request with an illegal position raises `out_err` one cycle later. Illegal positions are s=0 or s>16 in signed mode, and s>15 in unsigned mode. In that case `out_data` keeps its previous value, `out_sat` is 0 and `sticky_q` does not change.
- R9: `out_valid` equals `in_valid` delayed by one clock. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| in_mode | input | 1 | 0 = signed range, 1 = unsigned range |
| in_sat | input | 5 | Saturation position |
| in_opnd | input | 32 | Two packed signed 16-bit lanes |
| sticky_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_data | output | 32 | Packed clamped lanes |
| out_sat | output | 1 | Some lane was clamped in this operation |
| out_err | output | 1 | Request had an illegal position |
| sticky_q | output | 1 | Sticky clamp flag |

## Verification
The assertions assume that `in_mode`, `in_sat` and `in_opnd` are held valid only during the cycle in which `in_valid` is high. They also assume that reset is released before the first request.

The bench drives each request for exactly one cycle and then drops `in_valid`. It sweeps every position from 0 to 18, and also 31, in both modes. The sweep uses a lattice of operand values plus the values on either side of each range limit, so both legal and illegal positions are exercised.

// File: rtl/hsat_pkg.sv
package hsat_pkg;
  typedef enum logic {
    MODE_SIGNED   = 1'b0,
    MODE_UNSIGNED = 1'b1
  } sat_mode_e;
endpackage

// File: rtl/hsat_cfg_check.sv
module hsat_cfg_check
  import hsat_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int SAT_W  = 5
) (
  input  sat_mode_e        mode,
  input  logic [SAT_W-1:0] sat,
  output logic             ok
);
  localparam logic [SAT_W-1:0] MAX_SIGNED   = SAT_W'(LANE_W);
  localparam logic [SAT_W-1:0] MAX_UNSIGNED = SAT_W'(LANE_W - 1);

  always_comb begin
    if (mode == MODE_UNSIGNED) ok = (sat <= MAX_UNSIGNED);
    else                       ok = (sat != '0) && (sat <= MAX_SIGNED);
  end
endmodule

// File: rtl/hsat_lane.sv
module hsat_lane
  import hsat_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int SAT_W  = 5
) (
  input  logic [LANE_W-1:0] din,
  input  sat_mode_e         mode,
  input  logic [SAT_W-1:0]  sat,
  output logic [LANE_W-1:0] dout,
  output logic              clamped
);
  localparam logic [LANE_W-1:0] ONE = LANE_W'(1);

  logic signed [LANE_W-1:0] x, hi, lo;

  always_comb begin
    x = $signed(din);
    if (mode == MODE_UNSIGNED) begin
      hi = $signed((ONE << sat) - ONE);
      lo = '0;
    end else begin
      hi = $signed((ONE << (sat - SAT_W'(1))) - ONE);
      lo = ~hi;
    end
    if (x > hi) begin
      dout    = hi;
      clamped = 1'b1;
    end else if (x < lo) begin
      dout    = lo;
      clamped = 1'b1;
    end else begin
      dout    = x;
      clamped = 1'b0;
    end
  end
endmodule

// File: rtl/hsat_sticky.sv
module hsat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
  assert_sticky_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);
endmodule

// File: rtl/hsat_dual_unit.sv
module hsat_dual_unit
  import hsat_pkg::*;
#(
  parameter  int LANE_W    = 16,
  parameter  int NUM_LANES = 2,
  localparam int SAT_W     = $clog2(LANE_W + 1),
  localparam int DATA_W    = LANE_W * NUM_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [SAT_W-1:0]  in_sat,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic              sticky_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sat,
  output logic              out_err,
  output logic              sticky_q
);
  sat_mode_e                mode;
  logic                     cfg_ok;
  logic                     accept;
  logic [DATA_W-1:0]        lane_res;
  logic [NUM_LANES-1:0]     lane_clamp;
  logic                     any_clamp;

  assign mode      = sat_mode_e'(in_mode);
  assign accept    = in_valid && cfg_ok;
  assign any_clamp = |lane_clamp;

  hsat_cfg_check #(.LANE_W(LANE_W), .SAT_W(SAT_W)) u_cfg (
    .mode (mode),
    .sat  (in_sat),
    .ok   (cfg_ok)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    hsat_lane #(.LANE_W(LANE_W), .SAT_W(SAT_W)) u_lane (
      .din     (in_opnd[i*LANE_W +: LANE_W]),
      .mode    (mode),
      .sat     (in_sat),
      .dout    (lane_res[i*LANE_W +: LANE_W]),
      .clamped (lane_clamp[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && !cfg_ok;
      out_sat   <= accept && any_clamp;
      if (accept) out_data <= lane_res;
    end
  end

  hsat_sticky u_sticky (
    .clk (clk),
    .rst (rst),
    .set (accept && any_clamp),
    .clr (sticky_clr),
    .q   (sticky_q)
  );

  assert_valid_delay_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));
  assert_err_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_ok) |=> (out_err && !out_sat && $stable(out_data)));
  assert_signed_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == MODE_SIGNED && in_sat == SAT_W'(LANE_W))
      |=> (out_data == $past(in_opnd) && !out_sat));
  assert_unsigned_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == MODE_UNSIGNED && in_sat == '0) |=> (out_data == '0));
endmodule

// File: tb/tb_hsat_dual_unit.sv
module tb_hsat_dual_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_mode;
  logic [4:0]  in_sat;
  logic [31:0] in_opnd;
  logic        sticky_clr;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_sat;
  logic        out_err;
  logic        sticky_q;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_data = '0;
  logic        exp_sticky = 1'b0;

  always #2.5 clk = ~clk;

  hsat_dual_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_sat(in_sat), .in_opnd(in_opnd), .sticky_clr(sticky_clr),
    .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat),
    .out_err(out_err), .sticky_q(sticky_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] clampv(input logic [15:0] v, input bit uns,
                                         input int s);
    int x, lo, hi;
    x = int'($signed(v));
    if (uns) begin lo = 0; hi = (1 << s) - 1; end
    else begin lo = -(1 << (s - 1)); hi = (1 << (s - 1)) - 1; end
    if (x > hi) x = hi;
    if (x < lo) x = lo;
    return x[15:0];
  endfunction

  task automatic run_op(input bit uns, input int s, input logic [31:0] opnd,
                        input bit clr);
    bit legal;
    logic [31:0] res;
    bit sat;
    legal = uns ? (s <= 15) : (s >= 1 && s <= 16);
    res = exp_data;
    sat = 1'b0;
    if (legal) begin
      res = {clampv(opnd[31:16], uns, s), clampv(opnd[15:0], uns, s)};
      sat = (res != opnd);
    end
    @(negedge clk);
    in_valid = 1'b1; in_mode = uns; in_sat = 5'(s); in_opnd = opnd;
    sticky_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; sticky_clr = 1'b0;
    if (legal) exp_data = res;
    if (sat) exp_sticky = 1'b1;
    else if (clr) exp_sticky = 1'b0;
    chk(out_valid == 1'b1, "R9 out_valid", 32'(out_valid), 32'd1);
    chk(out_err == !legal, "R8 out_err", 32'(out_err), 32'(!legal));
    chk(out_data == exp_data, uns ? "R3 data" : "R2 data", out_data, exp_data);
    chk(out_sat == sat, "R5 out_sat", 32'(out_sat), 32'(sat));
    chk(sticky_q == exp_sticky, "R6 sticky", 32'(sticky_q), 32'(exp_sticky));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_sat = '0; in_opnd = '0;
    sticky_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk({out_valid, out_sat, out_err, sticky_q} == 4'b0, "R9 reset flags",
        32'({out_valid, out_sat, out_err, sticky_q}), 32'd0);
    chk(out_data == '0, "R9 reset data", out_data, 32'd0);

    // R1: only the high lane clamps, low lane passes, positions kept
    run_op(1'b0, 8, 32'h7000_0012, 1'b0);
    chk(out_data == 32'h007F_0012, "R1 lane placement", out_data, 32'h007F_0012);
    run_op(1'b1, 4, 32'h0003_FFF0, 1'b0);
    chk(out_data == 32'h0003_0000, "R1 lane low negative", out_data, 32'h0003_0000);

    // R7: clear alone, clear with saturation in the same cycle
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0; exp_sticky = 1'b0;
    chk(sticky_q == 1'b0, "R7 clear", 32'(sticky_q), 32'd0);
    run_op(1'b0, 12, 32'h0001_0002, 1'b0);
    chk(sticky_q == 1'b0, "R6 no-sat keeps 0", 32'(sticky_q), 32'd0);
    run_op(1'b0, 4, 32'h0100_0000, 1'b1);
    chk(sticky_q == 1'b1, "R7 sat wins over clear", 32'(sticky_q), 32'd1);
    run_op(1'b1, 15, 32'h0005_0006, 1'b0);
    chk(sticky_q == 1'b1, "R6 no-sat keeps 1", 32'(sticky_q), 32'd1);

    // R4 corner positions
    run_op(1'b0, 16, 32'h8000_7FFF, 1'b0);
    chk(out_data == 32'h8000_7FFF && !out_sat, "R4 signed pass", out_data, 32'h8000_7FFF);
    run_op(1'b1, 0, 32'h0000_0000, 1'b0);
    chk(!out_sat, "R4 unsigned zero input", 32'(out_sat), 32'd0);
    run_op(1'b1, 0, 32'h0000_0001, 1'b0);
    chk(out_sat && out_data == '0, "R4 unsigned zero clamps", out_data, 32'd0);

    // sweep both modes, legal and illegal positions
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 20; s++) begin
        int sv;
        int hi, lo;
        sv = (s == 19) ? 31 : s;
        hi = m ? ((1 << sv) - 1) : ((1 << (sv - 1)) - 1);
        lo = m ? 0 : -(1 << (sv - 1));
        for (int k = 0; k < 256; k++) begin
          logic [15:0] a;
          a = 16'(k * 257);
          run_op(m[0], sv, {a ^ 16'h5A3C, a}, 1'b0);
        end
        if (sv <= 16) begin
          run_op(m[0], sv, {16'(hi + 1), 16'(hi)}, 1'b0);
          run_op(m[0], sv, {16'(lo), 16'(lo - 1)}, 1'b0);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule